// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a byte-wide NOR flash device. It watches single-cycle bus write strobes carrying an address and a data byte and recognises the multi-cycle command sequences of the part: read/reset, autoselect, byte program, block erase (with extra blocks appended inside a timeout window), chip erase, erase suspend and erase resume. Every command except the one-write forms must be preceded by two coded unlock writes. Erase also needs a second unlock pair before its confirm byte. A write that breaks a sequence drops the decoder back to read-array mode.

Recognised operations leave as one-cycle request pulses towards an internal program/erase controller. That controller answers with a one-cycle `ctrl_done`. The decoder also picks what the read data bus shows: the caller's array read data, a signature byte, or the controller's status byte. Reads are combinational on the shared address bus.

Two counts and an address split fix the timing and decoding. The block index is the top `BLK_BITS` address bits. The coded address match uses only the low `CODED_W` bits. The erase window is `ERASE_WIN` cycles long.

The states are:
- `ST_READ_ARRAY` and `ST_SUSPENDED`: the two base states.
- `ST_UNLK1` and `ST_UNLK2`: the first unlock.
- `ST_AUTOSEL`: autoselect.
- `ST_PGM_WAIT`: waiting for the program data write.
- `ST_ERS_SETUP`, `ST_ERS_UNLK1` and `ST_ERS_UNLK2`: the erase prefix.
- `ST_ERS_WIN`: the append window.
- `ST_BUSY_PGM` and `ST_BUSY_ERS`: an operation is running.

The transitions are:
- unlock advance.
- command dispatch.
- fallback to base.
- program fire.
- block-erase open.
- window append.
- window expiry.
- window abort.
- chip-erase fire.
- suspend.
- resume.
- done return.

The base state is `ST_SUSPENDED` while an erase is suspended and `ST_READ_ARRAY` otherwise.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is array (0) and `rdata` equals `arr_rdata`. No request pulse is high.
- R2: The unlock writes are AAh to address 555h and then 55h to address AAAh. Only `addr[11:0]` is compared and `addr[17:12]` is ignored. Any other low address bits do not unlock.
- R3: The following return the decoder to read-array mode (`rd_mode` 0):
  - a single F0h write to any address, from array or autoselect mode;
  - an F0h command written to 555h after the unlock.
- R4: An unlock followed by 90h at 555h enters signature mode (`rd_mode` 1). In that mode `addr[1:0]` selects the byte:
  - 00 reads 20h;
  - 01 reads `DEV_ID`;
  - 10 reads 01h if `blk_prot[addr[17:15]]` is set and 00h otherwise;
  - 11 reads 00h.
- R5: An unlock followed by A0h at 555h makes the next write a program:
  - `pgm_req` is high for exactly the one cycle after that strobe, with `pgm_addr`/`pgm_data` equal to the strobe's address and data;
  - `rd_mode` is status (2) and `rdata` equals `stat_in` until `ctrl_done`.
- R6: Block erase is the unlock, 80h at 555h, a second unlock pair, then 30h at any address. The 30h write selects block `addr[17:15]` and opens the window, during which `rd_mode` is status. `ers_start` rises in the cycle that begins `ERASE_WIN` clock edges after the edge that sampled the last 30h strobe.
- R7: Each further 30h write inside the window adds its block to `ers_mask` (bit n for block n) and restarts the window.
- R8: In place of 30h, 10h written to 555h starts a chip erase. `ers_start` is high in the cycle after that strobe, with `ers_mask` all ones.
- R9: Any other write inside a sequence or inside the window returns the decoder to read-array mode without issuing any request. This covers wrong data, wrong address or an unknown command byte.
- R10: While an erase runs, a B0h write at any address pulses `susp_req` for one cycle. While suspended, reads of a block in `ers_mask` give status and reads of other blocks give array data.
- R11: While suspended, a single 30h write pulses `resume_req` for one cycle and returns `rd_mode` to status.
- R12: While suspended, an unlocked program to a block in `ers_mask` issues no `pgm_req` and the decoder stays suspended. A program to any other block is issued, and its `ctrl_done` returns the decoder to the suspended state.
- R13: While a program is busy, writes are ignored. `ctrl_done` returns the decoder to the base state, and after an erase also clears `ers_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | One-cycle write strobe |
| addr | input | 18 | Bus address for writes and reads |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data selected by the read mode |
| rd_mode | output | 2 | 0 array, 1 signature, 2 status |
| arr_rdata | input | 8 | Array read data from the caller at `addr` |
| stat_in | input | 8 | Status byte from the program/erase controller |
| blk_prot | input | 8 | Per-block protection flags |
| ctrl_done | input | 1 | Controller finished the running operation |
| pgm_req | output | 1 | Program request pulse |
| pgm_addr | output | 18 | Program address |
| pgm_data | output | 8 | Program data |
| ers_start | output | 1 | Erase start pulse |
| ers_mask | output | 8 | Blocks selected for erase |
| susp_req | output | 1 | Erase suspend pulse |
| resume_req | output | 1 | Erase resume pulse |

## Verification
A decoder stuck in a wrong state shows on `rd_mode` and `rdata` in the very next read, because the read mux follows the state with no register in between. That is why every scenario reads back the mode after each command write. A state that skips or repeats a step shows as a missing, doubled or early request pulse one cycle after the strobe that should have issued it. The erase window is checked by counting edges to `ers_start`. A corrupted block mask shows both in `ers_mask` at the start pulse and in which blocks read as status during suspend.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ_ARRAY,
        ST_UNLK1,
        ST_UNLK2,
        ST_AUTOSEL,
        ST_PGM_WAIT,
        ST_ERS_SETUP,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_ERS_WIN,
        ST_BUSY_PGM,
        ST_BUSY_ERS,
        ST_SUSPENDED
    } dec_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_SIG    = 2'd1,
        RD_STATUS = 2'd2
    } rd_mode_e;

    // Classified write cycle
    typedef struct packed {
        logic unlk1;    // AAh at coded 555h
        logic unlk2;    // 55h at coded AAAh
        logic at555;    // coded address equals 555h
        logic c_reset;  // F0h
        logic c_auto;   // 90h
        logic c_pgm;    // A0h
        logic c_ers;    // 80h
        logic c_blk;    // 30h
        logic c_chip;   // 10h
        logic c_susp;   // B0h
    } wr_decode_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int CODED_W = 12,
    parameter int DATA_W  = 8
) (
    input  logic [CODED_W-1:0] addr_lo,
    input  logic [DATA_W-1:0]  wdata,
    output wr_decode_t         dec
);
    localparam logic [CODED_W-1:0] ADR_A = CODED_W'(12'h555);
    localparam logic [CODED_W-1:0] ADR_B = CODED_W'(12'hAAA);

    always_comb begin
        dec.at555   = (addr_lo == ADR_A);
        dec.unlk1   = dec.at555 && (wdata == DATA_W'(8'hAA));
        dec.unlk2   = (addr_lo == ADR_B) && (wdata == DATA_W'(8'h55));
        dec.c_reset = (wdata == DATA_W'(8'hF0));
        dec.c_auto  = (wdata == DATA_W'(8'h90));
        dec.c_pgm   = (wdata == DATA_W'(8'hA0));
        dec.c_ers   = (wdata == DATA_W'(8'h80));
        dec.c_blk   = (wdata == DATA_W'(8'h30));
        dec.c_chip  = (wdata == DATA_W'(8'h10));
        dec.c_susp  = (wdata == DATA_W'(8'hB0));
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 8,
    parameter int BLK_BITS  = 3,
    parameter int ERASE_WIN = 16,
    localparam int NBLK     = 1 << BLK_BITS,
    localparam int CNT_W    = $clog2(ERASE_WIN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  wr_decode_t          dec,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                ctrl_done,
    output dec_state_e          state,
    output logic                susp_q,
    output logic [NBLK-1:0]     ers_mask,
    output logic                pgm_req,
    output logic [ADDR_W-1:0]   pgm_addr,
    output logic [DATA_W-1:0]   pgm_data,
    output logic                ers_start,
    output logic                susp_req,
    output logic                resume_req
);
    logic [BLK_BITS-1:0] blk;
    assign blk = addr[ADDR_W-1 -: BLK_BITS];

    dec_state_e          nxt, base;
    logic [NBLK-1:0]     nxt_mask;
    logic                nxt_susp;
    logic                pgm_fire, ers_fire, susp_fire, res_fire;
    logic                cnt_clr, cnt_inc;
    logic [CNT_W-1:0]    cnt;

    always_comb begin
        base      = susp_q ? ST_SUSPENDED : ST_READ_ARRAY;
        nxt       = state;
        nxt_mask  = ers_mask;
        nxt_susp  = susp_q;
        pgm_fire  = 1'b0;
        ers_fire  = 1'b0;
        susp_fire = 1'b0;
        res_fire  = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        unique case (state)
            ST_READ_ARRAY, ST_AUTOSEL, ST_SUSPENDED: if (wr_stb) begin
                if (dec.unlk1) begin
                    nxt = ST_UNLK1;
                end else if (state == ST_SUSPENDED && dec.c_blk) begin
                    nxt      = ST_BUSY_ERS;
                    nxt_susp = 1'b0;
                    res_fire = 1'b1;
                end else begin
                    nxt = base;
                end
            end
            ST_UNLK1: if (wr_stb) nxt = dec.unlk2 ? ST_UNLK2 : base;
            ST_UNLK2: if (wr_stb) begin
                nxt = base;
                if (dec.at555) begin
                    if (dec.c_pgm)                nxt = ST_PGM_WAIT;
                    else if (!susp_q && dec.c_auto) nxt = ST_AUTOSEL;
                    else if (!susp_q && dec.c_ers)  nxt = ST_ERS_SETUP;
                end
            end
            ST_PGM_WAIT: if (wr_stb) begin
                if (susp_q && ers_mask[blk]) begin
                    nxt = base;
                end else begin
                    nxt      = ST_BUSY_PGM;
                    pgm_fire = 1'b1;
                end
            end
            ST_ERS_SETUP: if (wr_stb) nxt = dec.unlk1 ? ST_ERS_UNLK1 : ST_READ_ARRAY;
            ST_ERS_UNLK1: if (wr_stb) nxt = dec.unlk2 ? ST_ERS_UNLK2 : ST_READ_ARRAY;
            ST_ERS_UNLK2: if (wr_stb) begin
                if (dec.c_blk) begin
                    nxt           = ST_ERS_WIN;
                    nxt_mask      = '0;
                    nxt_mask[blk] = 1'b1;
                    cnt_clr       = 1'b1;
                end else if (dec.c_chip && dec.at555) begin
                    nxt      = ST_BUSY_ERS;
                    nxt_mask = '1;
                    ers_fire = 1'b1;
                end else begin
                    nxt = ST_READ_ARRAY;
                end
            end
            ST_ERS_WIN: begin
                if (wr_stb) begin
                    if (dec.c_blk) begin
                        nxt_mask[blk] = 1'b1;
                        cnt_clr       = 1'b1;
                    end else begin
                        nxt      = ST_READ_ARRAY;
                        nxt_mask = '0;
                    end
                end else if (cnt == CNT_W'(ERASE_WIN - 1)) begin
                    nxt      = ST_BUSY_ERS;
                    ers_fire = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_BUSY_PGM: if (ctrl_done) nxt = base;
            ST_BUSY_ERS: begin
                if (ctrl_done) begin
                    nxt      = ST_READ_ARRAY;
                    nxt_mask = '0;
                end else if (wr_stb && dec.c_susp) begin
                    nxt       = ST_SUSPENDED;
                    nxt_susp  = 1'b1;
                    susp_fire = 1'b1;
                end
            end
            default: nxt = ST_READ_ARRAY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ_ARRAY;
        else        state <= nxt;
    end

    // Output and context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            susp_q     <= 1'b0;
            ers_mask   <= '0;
            cnt        <= '0;
            pgm_req    <= 1'b0;
            pgm_addr   <= '0;
            pgm_data   <= '0;
            ers_start  <= 1'b0;
            susp_req   <= 1'b0;
            resume_req <= 1'b0;
        end else begin
            susp_q     <= nxt_susp;
            ers_mask   <= nxt_mask;
            pgm_req    <= pgm_fire;
            ers_start  <= ers_fire;
            susp_req   <= susp_fire;
            resume_req <= res_fire;
            if (cnt_clr)      cnt <= '0;
            else if (cnt_inc) cnt <= cnt + 1'b1;
            if (pgm_fire) begin
                pgm_addr <= addr;
                pgm_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int          BLK_BITS = 3,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  MFR_ID   = 8'h20,
    parameter logic [7:0]  DEV_ID   = 8'hD5,
    localparam int         NBLK     = 1 << BLK_BITS
) (
    input  dec_state_e           state,
    input  logic                 susp_q,
    input  logic [NBLK-1:0]      ers_mask,
    input  logic [BLK_BITS-1:0]  rd_blk,
    input  logic [1:0]           sel,
    input  logic [NBLK-1:0]      blk_prot,
    input  logic [DATA_W-1:0]    arr_rdata,
    input  logic [DATA_W-1:0]    stat_in,
    output rd_mode_e             mode,
    output logic [DATA_W-1:0]    rdata
);
    logic [DATA_W-1:0] sig;

    always_comb begin
        unique case (state)
            ST_BUSY_PGM, ST_BUSY_ERS, ST_ERS_WIN: mode = RD_STATUS;
            ST_AUTOSEL:                           mode = RD_SIG;
            default: mode = (susp_q && ers_mask[rd_blk]) ? RD_STATUS : RD_ARRAY;
        endcase
    end

    always_comb begin
        unique case (sel)
            2'd0:    sig = DATA_W'(MFR_ID);
            2'd1:    sig = DATA_W'(DEV_ID);
            2'd2:    sig = DATA_W'(blk_prot[rd_blk]);
            default: sig = '0;
        endcase
    end

    always_comb begin
        unique case (mode)
            RD_SIG:    rdata = sig;
            RD_STATUS: rdata = stat_in;
            default:   rdata = arr_rdata;
        endcase
    end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 18,
    parameter int          DATA_W    = 8,
    parameter int          BLK_BITS  = 3,
    parameter int          CODED_W   = 12,
    parameter int          ERASE_WIN = 16,
    parameter logic [7:0]  MFR_ID    = 8'h20,
    parameter logic [7:0]  DEV_ID    = 8'hD5,
    localparam int         NBLK      = 1 << BLK_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic [1:0]         rd_mode,
    input  logic [DATA_W-1:0]  arr_rdata,
    input  logic [DATA_W-1:0]  stat_in,
    input  logic [NBLK-1:0]    blk_prot,
    input  logic               ctrl_done,
    output logic               pgm_req,
    output logic [ADDR_W-1:0]  pgm_addr,
    output logic [DATA_W-1:0]  pgm_data,
    output logic               ers_start,
    output logic [NBLK-1:0]    ers_mask,
    output logic               susp_req,
    output logic               resume_req
);
    wr_decode_t dec;
    dec_state_e state;
    rd_mode_e   mode;
    logic       susp_q;

    flash_cmd_match #(.CODED_W(CODED_W), .DATA_W(DATA_W)) match_i (
        .addr_lo (addr[CODED_W-1:0]),
        .wdata   (wdata),
        .dec     (dec)
    );

    flash_cmd_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BITS(BLK_BITS), .ERASE_WIN(ERASE_WIN)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .dec        (dec),
        .addr       (addr),
        .wdata      (wdata),
        .ctrl_done  (ctrl_done),
        .state      (state),
        .susp_q     (susp_q),
        .ers_mask   (ers_mask),
        .pgm_req    (pgm_req),
        .pgm_addr   (pgm_addr),
        .pgm_data   (pgm_data),
        .ers_start  (ers_start),
        .susp_req   (susp_req),
        .resume_req (resume_req)
    );

    flash_rd_mux #(
        .BLK_BITS(BLK_BITS), .DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) mux_i (
        .state     (state),
        .susp_q    (susp_q),
        .ers_mask  (ers_mask),
        .rd_blk    (addr[ADDR_W-1 -: BLK_BITS]),
        .sel       (addr[1:0]),
        .blk_prot  (blk_prot),
        .arr_rdata (arr_rdata),
        .stat_in   (stat_in),
        .mode      (mode),
        .rdata     (rdata)
    );

    assign rd_mode = mode;
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int          DATA_W = 8,
    parameter int          NBLK   = 8,
    parameter logic [7:0]  MFR_ID = 8'h20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_stb,
    input logic [DATA_W-1:0]  wdata,
    input logic [1:0]         sel,
    input logic [1:0]         rd_mode,
    input logic [DATA_W-1:0]  rdata,
    input logic               pgm_req,
    input logic               ers_start,
    input logic [NBLK-1:0]    ers_mask,
    input logic               susp_req,
    input logic               resume_req
);
    p_one_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pgm_req, ers_start, susp_req, resume_req}));

    p_pgm_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |=> !pgm_req);

    p_pgm_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> rd_mode == 2'd2);

    p_mask_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ers_start |-> ers_mask != '0);

    p_chip_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ers_start && $past(wr_stb) && $past(wdata) == DATA_W'(8'h10)) |-> (&ers_mask));

    p_susp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |-> ($past(wr_stb) && $past(wdata) == DATA_W'(8'hB0)));

    p_resume_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |-> rd_mode == 2'd2);

    p_sig_mfr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd1 && sel == 2'd0) |-> rdata == DATA_W'(MFR_ID));
endmodule

bind flash_cmd_decoder flash_cmd_checker #(
    .DATA_W(DATA_W), .NBLK(NBLK), .MFR_ID(MFR_ID)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .wdata      (wdata),
    .sel        (addr[1:0]),
    .rd_mode    (rd_mode),
    .rdata      (rdata),
    .pgm_req    (pgm_req),
    .ers_start  (ers_start),
    .ers_mask   (ers_mask),
    .susp_req   (susp_req),
    .resume_req (resume_req)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
    localparam int WIN = 16;
    localparam logic [7:0] DEV = 8'hD5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata, arr_rdata, pgm_data, ers_mask;
    logic [7:0]  stat_in = 8'h48;
    logic [7:0]  blk_prot = 8'b0010_0100;
    logic [1:0]  rd_mode;
    logic        ctrl_done = 1'b0;
    logic        pgm_req, ers_start, susp_req, resume_req;
    logic [17:0] pgm_addr;

    int checks = 0;
    int errors = 0;
    bit summary_done = 0;

    always #4 clk = ~clk;

    assign arr_rdata = addr[7:0] ^ 8'h5A;

    flash_cmd_decoder #(.ERASE_WIN(WIN), .DEV_ID(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rd_mode(rd_mode), .arr_rdata(arr_rdata), .stat_in(stat_in),
        .blk_prot(blk_prot), .ctrl_done(ctrl_done), .pgm_req(pgm_req),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .ers_start(ers_start),
        .ers_mask(ers_mask), .susp_req(susp_req), .resume_req(resume_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic unlock(input logic [7:0] cmd);
        wr(18'h00555, 8'hAA);
        wr(18'h00AAA, 8'h55);
        wr(18'h00555, cmd);
    endtask

    task automatic erase_prefix();
        unlock(8'h80);
        wr(18'h00555, 8'hAA);
        wr(18'h00AAA, 8'h55);
    endtask

    task automatic done_pulse();
        @(negedge clk); ctrl_done = 1'b1;
        @(negedge clk); ctrl_done = 1'b0;
    endtask

    task automatic rd(input logic [17:0] a);
        addr = a; #1;
    endtask

    function automatic logic [3:0] pulses();
        return {pgm_req, ers_start, susp_req, resume_req};
    endfunction

    task automatic t_reset();
        rd(18'h00013);
        check("R1 mode", rd_mode, 2'd0);
        check("R1 rdata", rdata, 8'h13 ^ 8'h5A);
        check("R1 pulses", pulses(), 4'd0);
    endtask

    task automatic t_autosel();
        unlock(8'h90);
        check("R4 mode", rd_mode, 2'd1);
        rd(18'h00000); check("R4 mfr", rdata, 8'h20);
        rd(18'h00001); check("R4 dev", rdata, DEV);
        rd(18'h28002); check("R4 prot blk5", rdata, 8'h01);
        rd(18'h18002); check("R4 prot blk3", rdata, 8'h00);
        rd(18'h00003); check("R4 sel3", rdata, 8'h00);
        wr(18'h12345, 8'hF0);
        check("R3 single reset", rd_mode, 2'd0);
    endtask

    task automatic t_unlock_mask();
        wr(18'h3F555, 8'hAA);
        wr(18'h2DAAA, 8'h55);
        wr(18'h1F555, 8'h90);
        check("R2 high bits ignored", rd_mode, 2'd1);
        unlock(8'hF0);
        check("R3 unlocked reset", rd_mode, 2'd0);
        wr(18'h00554, 8'hAA);
        wr(18'h00AAA, 8'h55);
        wr(18'h00555, 8'h90);
        check("R2 low bits matter", rd_mode, 2'd0);
        wr(18'h00555, 8'hAA);
        wr(18'h00AAA, 8'h54);
        wr(18'h00555, 8'h90);
        check("R9 bad unlock data", rd_mode, 2'd0);
    endtask

    task automatic t_program();
        unlock(8'hA0);
        wr(18'h12345, 8'h3C);
        check("R5 pgm_req", pgm_req, 1'b1);
        check("R5 pgm_addr", pgm_addr, 18'h12345);
        check("R5 pgm_data", pgm_data, 8'h3C);
        check("R5 status", rdata, stat_in);
        @(negedge clk);
        check("R5 one cycle", pgm_req, 1'b0);
        wr(18'h00000, 8'hF0);
        check("R13 ignored while busy", rd_mode, 2'd2);
        done_pulse();
        check("R13 done returns", rd_mode, 2'd0);
    endtask

    task automatic t_bad_cmd();
        unlock(8'h77);
        check("R9 unknown cmd", rd_mode, 2'd0);
        wr(18'h00100, 8'h11);
        check("R9 no request", pulses(), 4'd0);
    endtask

    task automatic t_block_erase();
        int n;
        erase_prefix();
        wr(18'h10000, 8'h30);
        check("R6 window status", rd_mode, 2'd2);
        wr(18'h30000, 8'h30);
        n = 0;
        while (!ers_start && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R6 window length", n, WIN);
        check("R7 mask", ers_mask, 8'b0100_0100);
        @(negedge clk);
        wr(18'h00777, 8'hB0);
        check("R10 susp_req", susp_req, 1'b1);
        rd(18'h10004); check("R10 erased blk status", rdata, stat_in);
        rd(18'h00004); check("R10 other blk array", rdata, 8'h04 ^ 8'h5A);
        unlock(8'hA0);
        wr(18'h30010, 8'h99);
        check("R12 blocked pgm", pgm_req, 1'b0);
        rd(18'h00004); check("R12 still suspended", rd_mode, 2'd0);
        rd(18'h30004); check("R12 still suspended erased", rd_mode, 2'd2);
        unlock(8'hA0);
        wr(18'h08010, 8'h66);
        check("R12 allowed pgm", pgm_req, 1'b1);
        done_pulse();
        rd(18'h10004); check("R12 back to suspend", rd_mode, 2'd2);
        rd(18'h08004); check("R12 other blk array", rd_mode, 2'd0);
        wr(18'h00000, 8'h30);
        check("R11 resume_req", resume_req, 1'b1);
        check("R11 status", rd_mode, 2'd2);
        done_pulse();
        check("R13 erase done mode", rd_mode, 2'd0);
        check("R13 mask cleared", ers_mask, 8'h00);
    endtask

    task automatic t_chip_erase();
        erase_prefix();
        wr(18'h00555, 8'h10);
        check("R8 ers_start", ers_start, 1'b1);
        check("R8 mask", ers_mask, 8'hFF);
        done_pulse();
        check("R8 done", rd_mode, 2'd0);
    endtask

    task automatic t_window_abort();
        bit seen = 0;
        erase_prefix();
        wr(18'h08000, 8'h30);
        wr(18'h00000, 8'h55);
        check("R9 abort mode", rd_mode, 2'd0);
        for (int i = 0; i < WIN + 4; i++) begin
            if (ers_start) seen = 1;
            @(negedge clk);
        end
        check("R9 no erase", seen, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_autosel();
        t_unlock_mask();
        t_program();
        t_bad_cmd();
        t_block_erase();
        t_chip_erase();
        t_window_abort();
        finish_run();
    end
endmodule